// File: doc/BRIEF.md
# Vectored interrupt controller with register access

The controller gathers up to 32 interrupt request lines into a single interrupt output for a processor. Each line is fixed by a parameter bit as edge-sensitive or level-sensitive. Requests are captured in a status register and qualified by an enable register. The controller reports the lowest-numbered request that is both captured and enabled through a vector register, so an interrupt handler can read the vector, service that source and repeat until the all-ones value shows that nothing remains.

Software reaches the controller through a 32-bit port. A write takes effect on the clock edge. Read data follows the address combinationally. Enable bits can be set or cleared one at a time through dedicated strobe registers, so no read-modify-write is needed. A two-bit master register gates the output. Its second bit moves the controller permanently into hardware mode, and only a reset leaves that mode. Until then software may raise interrupts itself by writing the status register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable and master registers read 0, `irq_out` is low and the vector register reads 0xFFFFFFFF.
- R2: The registers decode at these byte addresses: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master. The acknowledge, set-enable and clear-enable addresses read as 0.
- R3: A write to set-enable ORs its data into the enable register. A write to clear-enable clears the enable bits that are 1 in its data. In both cases the other enable bits keep their values.
- R4: A write to the enable address replaces the enable register, and a read of that address returns the stored value.
- R5: A write to acknowledge clears each status bit whose data bit is 1. Writing 0xFFFFFFFF clears every status bit whose source is not active.
- R6: For an edge-kind input (kind bit 1), a rising edge passes through a two-flop synchroniser and sets its status bit. The bit becomes visible after the third rising clock edge that follows the input change. It stays set after the input falls, until it is acknowledged.
- R7: For a level-kind input (kind bit 0), the status bit is set on every clock while the synchronised input is high. An acknowledge has no lasting effect until the input goes low.
- R8: The pending register reads as status AND enable.
- R9: The vector register returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R10: `irq_out` is high exactly when master bit 0 is 1 and at least one pending bit is 1.
- R11: Master bits 0 and 1 read back as written. Once bit 1 has been written as 1, it stays 1 until reset.
- R12: While master bit 1 is 0, a write to the status address ORs its data into the status register. While the bit is 1, such writes are ignored.
- R13: Status, pending and enable bits at or above N_SRC read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt request lines, asynchronous |
| reg_addr | input | 5 | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt output to the processor |

## Verification
The embedded assertions check, on every cycle, the effect of each set-enable and clear-enable strobe on the enable bits, the clearing effect of an acknowledge, the repeated setting of level-kind status, the stickiness of the hardware-mode bit, and the range of the vector. The bench scenarios are needed for the rest. These are the exact latency of the synchroniser on an edge input, the lowest-index choice among several pending sources, the gating of the output by the global enable, the refusal of software status writes in hardware mode, and the read-as-zero behaviour of unimplemented bits and write-only addresses.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [4:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_out
);
  localparam logic [31:0] IMPL = 32'((64'd1 << N_SRC) - 64'd1);
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08,
                         A_ACK  = 5'h0C, A_SET  = 5'h10, A_CLR  = 5'h14,
                         A_VEC  = 5'h18, A_MSTR = 5'h1C;

  logic [N_SRC-1:0] sy1, sy2, sy3;
  logic [31:0] status_q, enab_q, pend, vec, hit32, wd;
  logic        glob_en, hw_mode;

  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_enab = reg_wr && reg_addr == A_ENAB;
  wire wr_ack  = reg_wr && reg_addr == A_ACK;
  wire wr_set  = reg_wr && reg_addr == A_SET;
  wire wr_clr  = reg_wr && reg_addr == A_CLR;
  wire wr_mstr = reg_wr && reg_addr == A_MSTR;

  assign wd    = reg_wdata & IMPL;
  assign hit32 = 32'((sy2 & ~sy3 & EDGE_KIND) | (sy2 & ~EDGE_KIND));
  assign pend  = status_q & enab_q;
  assign irq_out = glob_en && (pend != 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= irq_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enab_q   <= '0;
      glob_en  <= 1'b0;
      hw_mode  <= 1'b0;
    end else begin
      status_q <= (status_q & ~(wr_ack ? wd : 32'd0)) | hit32 |
                  ((wr_stat && !hw_mode) ? wd : 32'd0);
      if (wr_enab)     enab_q <= wd;
      else if (wr_set) enab_q <= enab_q | wd;
      else if (wr_clr) enab_q <= enab_q & ~wd;
      if (wr_mstr) glob_en <= reg_wdata[0];
      hw_mode <= hw_mode | (wr_mstr & reg_wdata[1]);
    end
  end

  always_comb begin
    vec = 32'hFFFF_FFFF;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) vec = 32'(i);
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_PEND:  reg_rdata = pend;
      A_ENAB:  reg_rdata = enab_q;
      A_VEC:   reg_rdata = vec;
      A_MSTR:  reg_rdata = {30'd0, hw_mode, glob_en};
      default: reg_rdata = 32'd0;
    endcase
  end

  // R3
  set_enab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((enab_q & $past(wd)) == $past(wd)) &&
               ((enab_q & ~$past(wd)) == ($past(enab_q) & ~$past(wd))));
  // R3
  clr_enab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((enab_q & $past(wd)) == 32'd0) &&
               ((enab_q & ~$past(wd)) == ($past(enab_q) & ~$past(wd))));
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !wr_stat) |=> (status_q & $past(wd) & ~$past(hit32)) == 32'd0);
  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & 32'($past(sy2) & ~EDGE_KIND)) == 32'($past(sy2) & ~EDGE_KIND));
  // R11
  hw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> hw_mode);
  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 32'd0) |-> (vec < 32'(N_SRC)) && pend[vec[4:0]]);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  irq_vector_ctrl #(.N_SRC(N), .EDGE_KIND(8'hF0)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, string tag, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic rd(logic [4:0] a, string tag, logic [31:0] exp);
    @(negedge clk);
    peek(a, tag, exp);
  endtask

  task automatic t_reset;
    rd(5'h00, "R1 status", 0);
    rd(5'h08, "R1 enable", 0);
    rd(5'h1C, "R1 master", 0);
    rd(5'h18, "R1 vector", 32'hFFFFFFFF);
    chk("R1 irq_out", 32'(irq_out), 0);
  endtask

  task automatic t_enable;
    wr(5'h08, 32'h0F); rd(5'h08, "R4 enable write", 32'h0F);
    wr(5'h10, 32'h30); rd(5'h08, "R3 set-enable", 32'h3F);
    wr(5'h14, 32'h05); rd(5'h08, "R3 clear-enable", 32'h3A);
    rd(5'h10, "R2 set-enable reads zero", 0);
    wr(5'h10, 32'hFFFFFFFF); rd(5'h08, "R13 enable high bits", 32'hFF);
    wr(5'h08, 32'h0); rd(5'h08, "R4 enable cleared", 0);
  endtask

  task automatic t_edge;
    @(negedge clk); irq_in[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    peek(5'h00, "R6 not yet after two edges", 0);
    @(posedge clk); @(negedge clk);
    peek(5'h00, "R6 latched after third edge", 32'h20);
    irq_in[5] = 1'b0;
    repeat (5) @(negedge clk);
    peek(5'h00, "R6 held after fall", 32'h20);
    wr(5'h0C, 32'h20); rd(5'h00, "R5 ack clears", 0);
  endtask

  task automatic t_level;
    @(negedge clk); irq_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    peek(5'h00, "R7 level set", 32'h02);
    wr(5'h0C, 32'h02); rd(5'h00, "R7 ack while high", 32'h02);
    irq_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    peek(5'h00, "R7 held after drop", 32'h02);
    wr(5'h0C, 32'h02); rd(5'h00, "R7 ack after drop", 0);
  endtask

  task automatic t_vector;
    wr(5'h00, 32'h50); rd(5'h00, "R12 software set", 32'h50);
    rd(5'h04, "R8 pending masked", 0);
    rd(5'h18, "R9 vector none", 32'hFFFFFFFF);
    wr(5'h10, 32'h40);
    rd(5'h04, "R8 pending", 32'h40);
    rd(5'h18, "R9 vector single", 6);
    chk("R10 gated by global enable", 32'(irq_out), 0);
    wr(5'h1C, 32'h1); rd(5'h1C, "R11 master readback", 1);
    chk("R10 irq asserted", 32'(irq_out), 1);
    wr(5'h10, 32'h10); rd(5'h18, "R9 lowest wins", 4);
    wr(5'h0C, 32'h10); rd(5'h18, "R9 next source", 6);
    wr(5'h0C, 32'hFFFFFFFF); rd(5'h18, "R5 ack all", 32'hFFFFFFFF);
    chk("R10 irq dropped", 32'(irq_out), 0);
  endtask

  task automatic t_hw;
    wr(5'h00, 32'hFFFFFF00); rd(5'h00, "R13 high status bits", 0);
    wr(5'h1C, 32'h3); rd(5'h1C, "R11 both bits", 3);
    wr(5'h1C, 32'h1); rd(5'h1C, "R11 hw bit sticky", 3);
    wr(5'h1C, 32'h0); rd(5'h1C, "R11 global cleared", 2);
    wr(5'h00, 32'h08); rd(5'h00, "R12 write ignored in hw mode", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_enable; t_edge; t_level; t_vector; t_hw;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule